// File: doc/BRIEF.md
# Edge-Synchronised Clock Burst Generator

This block turns each transition of a slow input clock, which has no fixed relation to the local clock, into a short run of enable pulses in the fast system clock domain. Logic downstream can then do a fixed amount of work per input edge without running off a multiplied clock. The input is synchronised first. A small free-running counter then advances only while one chosen bit of it disagrees with a reference level derived from the input. Each input edge puts that bit out of agreement, and the counter runs until the bit catches up. The burst length therefore comes from the bit position alone, and no separate sequencer is needed.

The pulses of one burst fall on back-to-back fast-clock cycles, starting a fixed number of cycles after the input edge. They are not spread across the input period. A selector picks 2, 4 or 8 pulses per edge. A build-time parameter chooses whether both input edges trigger a burst or only rising ones. The block accepts a selector change only while it is idle, and it re-aligns its counter on that change so that the change itself emits no pulses.

Top module: `edge_burst_gen`

## Requirements
- R1: With both-edge triggering (BOTH_EDGES=1), every rising and every falling transition of `ref_clk_i` yields exactly 2, 4 or 8 pulses for `burst_sel_i` = 0, 1 or 2. Value 3 also gives 8.
- R2: The pulses of one burst are on consecutive clock cycles, forming a single unbroken run. `busy_o` stays high for the whole run.
- R3: A transition of `ref_clk_i` applied between clock edges sets `busy_o` after the third following rising clock edge. The first `pulse_o` high follows the fourth.
- R4: With rising-only triggering (BOTH_EDGES=0), a rising transition yields the selected count, using the same encoding as R1. A falling transition yields no pulses.
- R5: During reset `pulse_o` and `busy_o` are low. After reset is released, no burst is emitted until the input next changes, whether the input is held high or low.
- R6: Changing `burst_sel_i` while no burst is active emits no pulses. The new count applies from the next input transition.
- R7: A change of `burst_sel_i` during a burst does not alter that burst. The burst completes with the old count, and the new count applies to the following transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Slow input clock, asynchronous to `clk` |
| burst_sel_i | input | 2 | Pulses per edge: 0 gives 2, 1 gives 4, 2 or 3 gives 8 |
| pulse_o | output | 1 | One-cycle enable strobe per counter step |
| busy_o | output | 1 | High while a burst is in progress |

## Verification
The assertions assume that each level of `ref_clk_i` lasts longer than the synchroniser delay plus the longest burst. A transition that arrives mid-burst would cut that burst short, and the burst-length bound would no longer describe a well-formed run. The stimulus holds every input level for thirty fast cycles, which is well beyond eight pulses plus four cycles of latency. Selector changes are made both while the block is idle and deliberately in the middle of a burst, so that the deferral and re-alignment paths are exercised under the same spacing rule.

// File: rtl/ebg_pkg.sv
package ebg_pkg;

  typedef enum logic [1:0] {
    BURST_2  = 2'd0,
    BURST_4  = 2'd1,
    BURST_8  = 2'd2,
    BURST_8B = 2'd3
  } burst_sel_e;

  // Counter bit whose toggle period sets the burst length.
  function automatic int sel_to_bit(burst_sel_e s);
    case (s)
      BURST_2: return 1;
      BURST_4: return 2;
      default: return 3;
    endcase
  endfunction

endpackage

// File: rtl/ebg_sync.sv
module ebg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/ebg_ref.sv
module ebg_ref #(
  parameter bit BOTH_EDGES = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic armed_i,
  output logic tog_o
);

  logic prev_q;
  logic tog_q;
  logic tog_d;
  logic evt;

  generate
    if (BOTH_EDGES) begin : g_both
      assign evt = armed_i & (lvl_i ^ prev_q);
    end else begin : g_rise
      assign evt = armed_i & lvl_i & ~prev_q;
    end
  endgenerate

  always_comb begin
    tog_d = tog_q ^ evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      tog_q  <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      tog_q  <= tog_d;
    end
  end

  assign tog_o = tog_q;

endmodule

// File: rtl/ebg_count.sv
module ebg_count #(
  parameter int CNT_W = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             load_i,
  input  logic [IDX_W-1:0] load_idx_i,
  input  logic             ref_i,
  input  logic [IDX_W-1:0] cmp_idx_i,
  output logic             bit_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = inc_i | load_i;

  always_comb begin
    cnt_d = cnt_q;
    if (inc_i) begin
      cnt_d = cnt_q + 1'b1;
    end else if (load_i) begin
      // Realign: only the new compare bit carries the reference, lower bits clear.
      cnt_d = '0;
      cnt_d[load_idx_i] = ref_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign bit_o = cnt_q[cmp_idx_i];

endmodule

// File: rtl/edge_burst_gen.sv
module edge_burst_gen
  import ebg_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter bit BOTH_EDGES  = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_clk_i,
  input  logic [1:0] burst_sel_i,
  output logic       pulse_o,
  output logic       busy_o
);

  localparam int IDX_W   = $clog2(CNT_W);
  localparam int MAX_RUN = 1 << (CNT_W - 1);
  localparam int RUN_W   = CNT_W + 1;

  logic                 lvl;
  logic                 tog;
  logic                 cnt_bit;
  logic                 inc;
  logic                 sel_ld;
  logic                 armed;
  logic [SYNC_STAGES:0] warm_q;
  logic [SYNC_STAGES:0] warm_d;
  burst_sel_e           sel_q;
  burst_sel_e           sel_new;
  logic [IDX_W-1:0]     cmp_idx;
  logic [IDX_W-1:0]     new_idx;
  logic                 pulse_q;
  logic [RUN_W-1:0]     run_q;
  logic [RUN_W-1:0]     run_d;

  ebg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(ref_clk_i),
    .sync_o (lvl)
  );

  // Edge events are ignored until the synchroniser and edge history are valid.
  always_comb begin
    warm_d = {warm_q[SYNC_STAGES-1:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= '0;
    else        warm_q <= warm_d;
  end

  assign armed = warm_q[SYNC_STAGES];

  ebg_ref #(.BOTH_EDGES(BOTH_EDGES)) u_ref (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (lvl),
    .armed_i(armed),
    .tog_o  (tog)
  );

  assign sel_new = burst_sel_e'(burst_sel_i);
  assign cmp_idx = IDX_W'(sel_to_bit(sel_q));
  assign new_idx = IDX_W'(sel_to_bit(sel_new));

  // Clock enable of the counter: compare bit out of step with the reference.
  assign inc    = cnt_bit ^ tog;
  assign sel_ld = ~inc & (sel_new != sel_q);

  ebg_count #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc_i     (inc),
    .load_i    (sel_ld),
    .load_idx_i(new_idx),
    .ref_i     (tog),
    .cmp_idx_i (cmp_idx),
    .bit_o     (cnt_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= BURST_2;
    else if (sel_ld) sel_q <= sel_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= inc;
  end

  assign pulse_o = pulse_q;
  assign busy_o  = inc | pulse_q;

  // Length of the current run of counter steps, for the burst bound check.
  always_comb begin
    run_d = inc ? run_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  AST_BURST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> (run_q < RUN_W'(MAX_RUN)));  // R1

  AST_QUIET_UNTIL_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !inc);  // R5

  AST_REALIGN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ld |=> (!inc || (tog != $past(tog))));  // R6

  AST_SEL_HELD_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> $stable(sel_q));  // R7

endmodule

// File: tb/test_edge_burst_gen.sv
`timescale 1ns/1ps
module test_edge_burst_gen;

  logic       clk;
  logic       rst_n;
  logic       ref_clk;
  logic [1:0] sel;
  logic       pulse_b, busy_b, pulse_r, busy_r;

  int n_run;
  int n_fail;

  // {sel[1:0], level, pulses both-edge[3:0], pulses rising-only[3:0]}
  localparam int NVEC = 10;
  localparam logic [10:0] VEC [NVEC] = '{
    {2'd0, 1'b1, 4'd2, 4'd2},
    {2'd0, 1'b0, 4'd2, 4'd0},
    {2'd1, 1'b1, 4'd4, 4'd4},
    {2'd1, 1'b0, 4'd4, 4'd0},
    {2'd2, 1'b1, 4'd8, 4'd8},
    {2'd2, 1'b0, 4'd8, 4'd0},
    {2'd3, 1'b1, 4'd8, 4'd8},
    {2'd3, 1'b0, 4'd8, 4'd0},
    {2'd0, 1'b1, 4'd2, 4'd2},
    {2'd2, 1'b0, 4'd8, 4'd0}
  };

  edge_burst_gen #(.BOTH_EDGES(1'b1)) i_edge_burst_gen (
    .clk(clk), .rst_n(rst_n), .ref_clk_i(ref_clk), .burst_sel_i(sel),
    .pulse_o(pulse_b), .busy_o(busy_b)
  );

  edge_burst_gen #(.BOTH_EDGES(1'b0)) i_edge_burst_gen_rise (
    .clk(clk), .rst_n(rst_n), .ref_clk_i(ref_clk), .burst_sel_i(sel),
    .pulse_o(pulse_r), .busy_o(busy_r)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Selector change while idle: no pulse may appear (R6).
  task automatic set_sel(input logic [1:0] s);
    int cnt_b, cnt_r;
    cnt_b = 0; cnt_r = 0;
    sel = s;
    for (int i = 0; i < 4; i++) begin
      cyc();
      cnt_b += int'(pulse_b);
      cnt_r += int'(pulse_r);
    end
    check(cnt_b == 0, "R6 idle selector change, both-edge", cnt_b, 0);
    check(cnt_r == 0, "R6 idle selector change, rising-only", cnt_r, 0);
  endtask

  // Drive a new input level, count pulses and runs over a quiet window.
  task automatic run_edge(input logic lvl, input int exp_b, input int exp_r,
                          input int mid_at, input logic [1:0] mid_sel, input string req);
    int cnt_b, cnt_r, runs_b, runs_r;
    logic pv_b, pv_r;
    cnt_b = 0; cnt_r = 0; runs_b = 0; runs_r = 0; pv_b = 1'b0; pv_r = 1'b0;
    ref_clk = lvl;
    for (int i = 0; i < 30; i++) begin
      cyc();
      if (i == mid_at) sel = mid_sel;
      cnt_b += int'(pulse_b);
      cnt_r += int'(pulse_r);
      if (pulse_b && !pv_b) runs_b++;
      if (pulse_r && !pv_r) runs_r++;
      pv_b = pulse_b;
      pv_r = pulse_r;
    end
    check(cnt_b == exp_b, {req, " pulse count, both-edge"}, cnt_b, exp_b);
    check(cnt_r == exp_r, {req, " pulse count, rising-only"}, cnt_r, exp_r);
    check(runs_b == (exp_b != 0 ? 1 : 0), "R2 single contiguous run, both-edge", runs_b,
          exp_b != 0 ? 1 : 0);
    check(runs_r == (exp_r != 0 ? 1 : 0), "R2 single contiguous run, rising-only", runs_r,
          exp_r != 0 ? 1 : 0);
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0;
    rst_n = 1'b0; ref_clk = 1'b0; sel = 2'd0;
    repeat (3) cyc();
    check(!pulse_b && !busy_b, "R5 reset state, both-edge", int'({busy_b, pulse_b}), 0);
    check(!pulse_r && !busy_r, "R5 reset state, rising-only", int'({busy_r, pulse_r}), 0);
    rst_n = 1'b1;
    repeat (6) cyc();

    // Vector table: R1 and R4 counts, R2 contiguity, R6 on each selector change.
    for (int v = 0; v < NVEC; v++) begin
      set_sel(VEC[v][10:9]);
      run_edge(VEC[v][8], int'(VEC[v][7:4]), int'(VEC[v][3:0]), -1, VEC[v][10:9],
               VEC[v][8] ? "R1/R4 rising edge" : "R1/R4 falling edge");
    end

    // R3: latency from an input change between clock edges.
    set_sel(2'd0);
    ref_clk = 1'b1;
    cyc(); cyc();
    check(!busy_b && !pulse_b, "R3 idle after two edges", int'({busy_b, pulse_b}), 0);
    cyc();
    check(busy_b && !pulse_b, "R3 busy after third edge, both-edge", int'({busy_b, pulse_b}), 2);
    check(busy_r && !pulse_r, "R3 busy after third edge, rising-only", int'({busy_r, pulse_r}), 2);
    cyc();
    check(pulse_b == 1'b1, "R3 first pulse after fourth edge, both-edge", int'(pulse_b), 1);
    check(pulse_r == 1'b1, "R3 first pulse after fourth edge, rising-only", int'(pulse_r), 1);
    repeat (12) cyc();

    // R7: selector change in mid-burst is deferred.
    set_sel(2'd2);
    run_edge(1'b0, 8, 0, 3, 2'd0, "R7 burst keeps old count");
    run_edge(1'b1, 2, 2, -1, 2'd0, "R7 new count on next edge");

    // R5: reset with the input held high, then no burst after release.
    rst_n = 1'b0;
    repeat (3) cyc();
    check(!pulse_b && !busy_b, "R5 quiet in reset, both-edge", int'({busy_b, pulse_b}), 0);
    check(!pulse_r && !busy_r, "R5 quiet in reset, rising-only", int'({busy_r, pulse_r}), 0);
    rst_n = 1'b1;
    run_edge(1'b1, 0, 0, -1, 2'd0, "R5 no burst after release with input high");
    run_edge(1'b0, 2, 0, -1, 2'd0, "R5 first edge after reset");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule